// File: doc/BRIEF.md
# Edge-Latched Interrupt Controller with Message Dispatch

This block gathers eleven interrupt lines coming from bridge-side sources. It records the present level of every line and keeps a sticky pending bit for each line that has just gone high. Each source is placed in one of two delivery classes. When a source that is enabled in the mask goes from low to high, the block sends one 32-bit write toward the system fabric. The write is built from one of two programmable target words. The class of the source selects which target word is used. The target word with its low five bits cleared becomes the write address, and those five bits become the write data.

Software reaches the state through a simple word-indexed register port. Reads are combinational on `reg_rdata`, and writes take effect on the next clock edge. Outgoing writes pass through a valid/ready handshake. Behind that handshake is a FIFO that can hold an edge from every source at once while the fabric is stalled. When several sources rise in the same cycle, they are queued one per cycle, lowest source number first.

The sources sit on fixed bit positions:
- bits 0 to 5 are PCI lines A to F;
- bit 6 is an external line;
- bit 7 is a bus-error event;
- bit 8 is PS2;
- bit 9 is spare;
- bit 10 is the serial port.

Register word indices on `reg_addr`:
- 0: LVL, the live level, read-only.
- 1: ENA, the mask.
- 2: CLS, the class.
- 3: PND, the pending bits.
- 4: RQA, derived request A, read-only.
- 5: RQB, derived request B, read-only.
- 6: TGA, target word A.
- 7: TGB, target word B.

Top module: `irq_msg_ctrl`

## Requirements
- R1: Bit i of LVL (word 0) equals `src_i[i]` from one clock earlier, for all 11 sources.
- R2: A 0-to-1 change of `src_i[i]` sets PND bit i. A 1-to-0 change clears only LVL bit i and leaves PND unchanged.
- R3: RQA (word 4) reads LVL & ENA & ~CLS. RQB (word 5) reads LVL & ENA & CLS.
- R4: A read of PND (word 3) returns its current value and clears it at the clock edge. A write to PND clears it whatever the data. A rise that arrives in the same cycle as the clear still leaves its bit set.
- R5: A rise on a source whose ENA bit is 1 produces exactly one outgoing write. The write uses TGB when the source's CLS bit is 1, and TGA otherwise.
- R6: The outgoing write has `msg_addr` equal to the target word with bits [4:0] forced to zero, and `msg_data` equal to the target word's bits [4:0] zero-extended.
- R7: Writes to LVL, RQA and RQB have no effect on what those words read back.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` hold steady. Each cycle with both set removes exactly one write.
- R9: With `msg_ready` held low, simultaneous rises on all 11 enabled sources are all kept. They are delivered in ascending source order once the fabric accepts them.
- R10: After reset, ENA, CLS and PND read 0, and TGA and TGB read the parameter `DEF_TARGET`.
- R11: An input held high produces no further pending bit or write. A rise on a source whose ENA bit is 0 sets PND but produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Interrupt source levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears PND when it addresses word 3) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| msg_valid | output | 1 | Outgoing write is available |
| msg_ready | input | 1 | Fabric accepts the outgoing write |
| msg_addr | output | 32 | Outgoing write address |
| msg_data | output | 32 | Outgoing write data |

## Verification
Two functions can act on the pending register in the same clock edge: the clear caused by a software access, and the setting of a bit by a fresh rising edge. The bench provokes this by driving a read of PND in the same cycle that a second source rises. It then checks two things. The read must return only the older bit. The following read must return exactly the newly risen bit, which shows the clear did not swallow the new edge. A second overlap is also exercised: all sources rise at once while the fabric is stalled. It is judged by the order and count of the writes that drain afterwards.

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl #(
  parameter int          NSRC       = 11,
  parameter int          DEPTH      = 16,
  parameter logic [31:0] DEF_TARGET = 32'hFFF8_0003
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [31:0]     msg_addr,
  output logic [31:0]     msg_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [2:0] A_LVL = 3'd0, A_ENA = 3'd1, A_CLS = 3'd2, A_PND = 3'd3,
                         A_RQA = 3'd4, A_RQB = 3'd5, A_TGA = 3'd6, A_TGB = 3'd7;

  logic [NSRC-1:0] level_q, mask_q, cls_q, pend_q, disp_q, dsel_q;
  logic [31:0]     tgt0_q, tgt1_q;
  logic [31:0]     mem [DEPTH];
  logic [PW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q;
  logic [SW-1:0]   pick_idx;
  logic [NSRC-1:0] rise, pick_oh, req0, req1;
  logic            clr_pend, push, pop, full;
  logic [31:0]     push_val;

  assign rise     = src_i & ~level_q;
  assign clr_pend = (reg_wr || reg_rd) && reg_addr == A_PND;
  assign req0     = level_q & mask_q & ~cls_q;
  assign req1     = level_q & mask_q & cls_q;

  always_comb begin
    pick_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (disp_q[i]) pick_idx = SW'(i);
  end

  assign full     = cnt_q == CW'(DEPTH);
  assign push     = (|disp_q) && !full;
  assign pop      = msg_valid && msg_ready;
  assign pick_oh  = push ? (NSRC'(1) << pick_idx) : '0;
  assign push_val = dsel_q[pick_idx] ? tgt1_q : tgt0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      mask_q  <= '0;
      cls_q   <= '0;
      pend_q  <= '0;
      disp_q  <= '0;
      dsel_q  <= '0;
      tgt0_q  <= DEF_TARGET;
      tgt1_q  <= DEF_TARGET;
    end else begin
      level_q <= src_i;
      pend_q  <= (clr_pend ? '0 : pend_q) | rise;
      disp_q  <= (disp_q & ~pick_oh) | (rise & mask_q);
      dsel_q  <= (dsel_q & ~(rise & mask_q)) | (rise & mask_q & cls_q);
      if (reg_wr) begin
        case (reg_addr)
          A_ENA:   mask_q <= reg_wdata[NSRC-1:0];
          A_CLS:   cls_q  <= reg_wdata[NSRC-1:0];
          A_TGA:   tgt0_q <= reg_wdata;
          A_TGB:   tgt1_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign msg_valid = cnt_q != '0;
  assign msg_addr  = {mem[rp_q][31:5], 5'b0};
  assign msg_data  = {27'b0, mem[rp_q][4:0]};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LVL: reg_rdata[NSRC-1:0] = level_q;
      A_ENA: reg_rdata[NSRC-1:0] = mask_q;
      A_CLS: reg_rdata[NSRC-1:0] = cls_q;
      A_PND: reg_rdata[NSRC-1:0] = pend_q;
      A_RQA: reg_rdata[NSRC-1:0] = req0;
      A_RQB: reg_rdata[NSRC-1:0] = req1;
      A_TGA: reg_rdata = tgt0_q;
      A_TGB: reg_rdata = tgt1_q;
      default: ;
    endcase
  end

  p_rise_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> (pend_q & $past(rise)) == $past(rise));
  p_clear_on_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && rise == '0) |=> pend_q == '0);
  p_pend_only_from_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & ~$past(pend_q) & ~$past(rise)) == '0);
  p_msg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: tb/sim_irq_msg_ctrl.sv
module sim_irq_msg_ctrl;
  localparam int NSRC = 11;
  localparam logic [31:0] DEFT = 32'hFFF8_0003;
  localparam logic [31:0] T0 = 32'h1234_5667;
  localparam logic [31:0] T1 = 32'hABCD_EF1F;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_i = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msg_valid, msg_ready = 1;
  logic [31:0] msg_addr, msg_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_msg_ctrl #(.NSRC(NSRC), .DEPTH(16), .DEF_TARGET(DEFT)) u0 (
    .clk, .rst_n, .src_i, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .msg_valid, .msg_ready, .msg_addr, .msg_data);

  // each entry: {source index[3:0], enabled, class}
  localparam logic [5:0] VEC [8] = '{
    {4'd0, 1'b1, 1'b0}, {4'd3, 1'b1, 1'b1}, {4'd10, 1'b1, 1'b0}, {4'd6, 1'b0, 1'b0},
    {4'd8, 1'b1, 1'b1}, {4'd5, 1'b0, 1'b1}, {4'd7, 1'b1, 1'b0}, {4'd9, 1'b1, 1'b1}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  function automatic logic [31:0] ea(logic [31:0] t); return {t[31:5], 5'b0}; endfunction
  function automatic logic [31:0] ed(logic [31:0] t); return {27'b0, t[4:0]}; endfunction

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset values
    rd(3'd1, v); chk("R10 ena", v, 0);
    rd(3'd2, v); chk("R10 cls", v, 0);
    rd(3'd3, v); chk("R10 pnd", v, 0);
    rd(3'd6, v); chk("R10 tga", v, DEFT);
    rd(3'd7, v); chk("R10 tgb", v, DEFT);
    chk("R10 no msg", msg_valid, 0);
    wr(3'd6, T0); wr(3'd7, T1);

    // table walk: R2 R5 R6 R11 R1
    for (int k = 0; k < 8; k++) begin
      int idx; logic en, cl; logic [31:0] t;
      idx = int'(VEC[k][5:2]); en = VEC[k][1]; cl = VEC[k][0];
      wr(3'd1, 32'(en) << idx);
      wr(3'd2, 32'(cl) << idx);
      src_i[idx] = 1'b1;
      @(negedge clk);
      chk("R5 not yet", msg_valid, 0);
      @(negedge clk);
      chk(en ? "R5 dispatch" : "R11 masked no dispatch", msg_valid, en);
      t = cl ? T1 : T0;
      if (en) begin
        chk("R6 addr", msg_addr, ea(t));
        chk("R6 data", msg_data, ed(t));
      end
      rd(3'd0, v); chk("R1 level", v, 32'(1) << idx);
      rd(3'd3, v); chk("R2 pending", v, 32'(1) << idx);
      chk("R5 single write", msg_valid, 0);
      src_i[idx] = 1'b0;
      rd(3'd0, v);
      rd(3'd0, v); chk("R2 fall clears level", v, 0);
      rd(3'd3, v); chk("R2 fall leaves pnd", v, 0);
    end

    // R2: fall does not clear a pending bit
    wr(3'd1, 0);
    src_i[1] = 1; @(negedge clk); src_i[1] = 0; @(negedge clk); @(negedge clk);
    rd(3'd3, v); chk("R2 pend survives fall", v, 32'h002);

    // R3 derived requests and R7 read-only
    wr(3'd1, 32'h0AF); wr(3'd2, 32'h022);
    @(negedge clk); src_i = 11'h0F3;
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R3 rqa", v, 32'h081);
    rd(3'd5, v); chk("R3 rqb", v, 32'h022);
    wr(3'd0, 32'h7FF); wr(3'd4, 32'h7FF); wr(3'd5, 32'h0);
    rd(3'd0, v); chk("R7 lvl", v, 32'h0F3);
    rd(3'd4, v); chk("R7 rqa", v, 32'h081);
    rd(3'd5, v); chk("R7 rqb", v, 32'h022);
    src_i = '0; repeat (12) @(negedge clk);
    chk("R8 drained", msg_valid, 0);

    // R4 write clears regardless of data
    wr(3'd1, 0);
    src_i[4] = 1; @(negedge clk); src_i[4] = 0;
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R4 write clears", v, 0);

    // R4 same-cycle clear and new rise
    src_i[0] = 1; @(negedge clk); @(negedge clk);
    reg_rd = 1; reg_addr = 3'd3; src_i[1] = 1; #1 v = reg_rdata;
    chk("R4 read returns old", v, 32'h001);
    @(negedge clk); reg_rd = 0;
    rd(3'd3, v); chk("R4 new rise survives clear", v, 32'h002);
    src_i = '0; @(negedge clk);

    // R11 held high: one write only
    wr(3'd1, 32'h004); wr(3'd2, 0);
    src_i[2] = 1; @(negedge clk); @(negedge clk);
    chk("R11 first write", msg_valid, 1);
    rd(3'd3, v);
    begin
      int seen; seen = 0;
      for (int c = 0; c < 10; c++) begin @(negedge clk); if (msg_valid) seen++; end
      chk("R11 held no repeat", 32'(seen), 0);
    end
    rd(3'd3, v); chk("R11 held no pend", v, 0);
    src_i = '0; @(negedge clk);

    // R8 / R9 stall with all sources rising together
    msg_ready = 0;
    wr(3'd1, 32'h7FF); wr(3'd2, 32'h555);
    src_i = '1;
    repeat (3) @(negedge clk);
    v = msg_addr;
    repeat (20) @(negedge clk);
    chk("R8 valid held", msg_valid, 1);
    chk("R8 addr stable", msg_addr, v);
    msg_ready = 1;
    for (int k = 0; k < NSRC; k++) begin
      logic [31:0] t;
      t = ((32'h555 >> k) & 1) ? T1 : T0;
      chk($sformatf("R9 order %0d valid", k), msg_valid, 1);
      chk($sformatf("R9 order %0d addr", k), msg_addr, ea(t));
      chk($sformatf("R9 order %0d data", k), msg_data, ed(t));
      @(negedge clk);
    end
    chk("R9 all delivered", msg_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule